// File: doc/BRIEF.md
# Event Counter and Watchdog with a Steerable Prescaler

This block pairs an 8-bit event counter with a watchdog timer. One 8-bit prescaler is shared between them and is steered to one side or the other. A 6-bit mode register sets four things:

- where the counter's events come from: the instruction cycle, or edges on an external pin;
- which pin edge counts;
- which side owns the prescaler;
- the division ratio.

The ratio table depends on the owner. On the counter side the smallest division is by two. On the watchdog side it is by one. The side that does not own the prescaler advances once on every raw event it sees.

The clock is the instruction-cycle clock: one clock edge is one instruction cycle. The external pin is asynchronous and is synchronised inside the block. The watchdog tick is a one-cycle pulse that is synchronous to the clock. The counter's value is always visible on `cnt_value`. Writing the counter loads a new value and briefly holds off counting.

Two commands reset the watchdog's count: clear and sleep. The block records watchdog history in two flags, a timeout flag and a power-loss flag. Each command sets its own pair of flag values, and a timeout sets a third or fourth pair depending on whether the block was asleep. A timeout also raises a one-cycle reset request. All pins are plain control and status signals; there is no streaming data path, so there is no back-pressure.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset the counter reads 0, both flags read 1 and the reset request is low. The mode register holds 6'b111111, so the counter is on the external pin and the prescaler belongs to the watchdog. With the pin held still, the counter does not move.
- R2: Mode bit 5 selects the counter's source: 0 means one event every instruction cycle. With mode bit 3 at 1, the counter is not prescaled and advances by one per source event.
- R3: With mode bit 3 at 0, the prescaler serves the counter. Ratio code n (mode bits 2..0) makes the counter advance once every 2^(n+1) source events, from 1:2 at code 0 up to 1:256 at code 7.
- R4: With mode bit 5 at 1, the counter counts edges of the external pin after a two-flop synchroniser. Mode bit 4 at 0 counts rising edges and at 1 counts falling edges; an edge of the other kind has no effect.
- R5: A counter write loads `cnt_wdata` at the next clock edge. It clears the prescaler when the prescaler serves the counter. No increment happens at the two clock edges after the load. The counter wraps from 0xFF to 0x00.
- R6: The watchdog times out after 2^WDT_W watchdog events. With mode bit 3 at 1, a watchdog event is one prescaler output at ratio 2^n for code n (1:1 at code 0). With mode bit 3 at 0, each tick is a watchdog event. A timeout raises `wdt_reset_req` for exactly one cycle, at the edge where the last event is taken.
- R7: The clear command resets the watchdog count, and also the prescaler when the watchdog owns it. It sets the timeout flag to 1 and the power-loss flag to 1.
- R8: The sleep command resets the watchdog count the same way and enters sleep. It sets the timeout flag to 1 and the power-loss flag to 0. If clear and sleep arrive in the same cycle, sleep wins.
- R9: A timeout while awake sets the timeout flag to 0 and the power-loss flag to 1. A timeout while asleep sets both flags to 0 and ends sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | One-cycle watchdog time-base pulse |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode value: [5] source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio code |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter load value |
| wdt_clear | input | 1 | Clear-watchdog command |
| sleep_cmd | input | 1 | Sleep command |
| cnt_value | output | 8 | Current counter value |
| wdt_reset_req | output | 1 | One-cycle watchdog timeout reset request |
| flag_to | output | 1 | Timeout flag |
| flag_pl | output | 1 | Power-loss flag |

## Verification
- **Counter division.** The counter is run from the instruction cycle unprescaled and at ratio codes 0, 2 and 7. Each run is checked against floor((cycles minus two) / ratio). This shows the counter-side table starting at 1:2 and confirms the two-cycle hold after a load.
- **Pin edges.** Pin pulses are counted in both edge modes. A lone rising edge is applied in falling mode and must not be counted.
- **Watchdog division.** The watchdog is driven directly, at prescaler code 0 and at code 1. Its table starts at 1:1, unlike the counter's.
- **Restart and flags.** Clears and loads are applied mid-count; a prescaler that was not cleared would time out or tick one event early. Timeouts are taken awake, asleep, and with clear and sleep together, so that all four flag codes appear.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int PRE_W  = 8;
  localparam int CODE_W = $clog2(PRE_W);

  typedef struct packed {
    logic              src_pin;
    logic              fall_edge;
    logic              to_wdt;
    logic [CODE_W-1:0] code;
  } tw_mode_t;

  localparam int MODE_W = $bits(tw_mode_t);

  // Mask of prescaler bits that must all be set for an output tick.
  // The counter side divides by 2^(code+1); the watchdog side by 2^code.
  function automatic logic [PRE_W-1:0] ratio_mask(input logic to_wdt,
                                                  input logic [CODE_W-1:0] code);
    logic [CODE_W:0] sh;
    logic [PRE_W:0]  m;
    sh = {1'b0, code} + {{CODE_W{1'b0}}, ~to_wdt};
    m  = ({{PRE_W{1'b0}}, 1'b1} << sh) - {{PRE_W{1'b0}}, 1'b1};
    return m[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/tw_pin_edge.sv
module tw_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic fall_sel,
  output logic edge_ev
);
  // [0],[1] synchroniser, [2] previous synchronised level
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], pin_async};
  end

  always_comb begin
    if (fall_sel) edge_ev = sh_q[2] & ~sh_q[1];
    else          edge_ev = sh_q[1] & ~sh_q[2];
  end
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ev,
  input  logic [W-1:0] mask,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = ev & ~clr & ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (ev)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ev,
  output logic timeout
);
  logic [W-1:0] cnt_q;

  assign timeout = ev & ~clr & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (ev)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer
  import tw_pkg::*;
#(
  parameter int                CNT_W    = 8,
  parameter int                WDT_W    = 8,
  parameter logic [MODE_W-1:0] MODE_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              wdt_tick,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              wdt_clear,
  input  logic              sleep_cmd,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              wdt_reset_req,
  output logic              flag_to,
  output logic              flag_pl
);
  localparam int          HOLD_W   = 2;
  localparam logic [HOLD_W-1:0] HOLD_CYC = 2'd2;

  tw_mode_t          mode_q;
  logic [HOLD_W-1:0] hold_q;
  logic              asleep_q;

  logic pin_ev, src_ev, hold_act, cnt_ev;
  logic wd_clr, pre_clr, pre_ev, pre_tick, cnt_inc, wd_ev, timeout;
  logic [PRE_W-1:0] pre_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= tw_mode_t'(MODE_RST);
    else if (mode_we) mode_q <= tw_mode_t'(mode_wdata);
  end

  tw_pin_edge u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_async(ext_pin),
    .fall_sel (mode_q.fall_edge),
    .edge_ev  (pin_ev)
  );

  // Event steering between counter and watchdog
  always_comb begin
    src_ev   = mode_q.src_pin ? pin_ev : 1'b1;
    hold_act = cnt_we | (hold_q != '0);
    cnt_ev   = src_ev & ~hold_act;
    wd_clr   = wdt_clear | sleep_cmd;
    pre_clr  = mode_q.to_wdt ? wd_clr   : cnt_we;
    pre_ev   = mode_q.to_wdt ? wdt_tick : cnt_ev;
    pre_mask = ratio_mask(mode_q.to_wdt, mode_q.code);
    cnt_inc  = mode_q.to_wdt ? cnt_ev   : pre_tick;
    wd_ev    = mode_q.to_wdt ? pre_tick : wdt_tick;
  end

  tw_prescaler #(.W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pre_clr),
    .ev   (pre_ev),
    .mask (pre_mask),
    .tick (pre_tick)
  );

  tw_watchdog #(.W(WDT_W)) u_wdt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (wd_clr),
    .ev     (wd_ev),
    .timeout(timeout)
  );

  // Counter and its post-load hold window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_value <= '0;
      hold_q    <= '0;
    end else begin
      if (cnt_we)       cnt_value <= cnt_wdata;
      else if (cnt_inc) cnt_value <= cnt_value + 1'b1;

      if (cnt_we)              hold_q <= HOLD_CYC;
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end

  // Watchdog history flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_to       <= 1'b1;
      flag_pl       <= 1'b1;
      asleep_q      <= 1'b0;
      wdt_reset_req <= 1'b0;
    end else begin
      wdt_reset_req <= timeout;
      if (sleep_cmd) begin
        flag_to  <= 1'b1;
        flag_pl  <= 1'b0;
        asleep_q <= 1'b1;
      end else if (wdt_clear) begin
        flag_to <= 1'b1;
        flag_pl <= 1'b1;
      end else if (timeout) begin
        flag_to  <= 1'b0;
        flag_pl  <= ~asleep_q;
        asleep_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             wdt_clear,
  input logic             sleep_cmd,
  input logic [CNT_W-1:0] cnt_value,
  input logic             wdt_reset_req,
  input logic             flag_to,
  input logic             flag_pl
);
  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_value == $past(cnt_wdata));

  a_r5_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we ##1 !cnt_we |=> $stable(cnt_value));

  a_r6_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);

  a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clear && !sleep_cmd) |=> (flag_to && flag_pl));

  a_r7_clear_blocks_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clear || sleep_cmd) |=> !wdt_reset_req);

  a_r8_sleep_flags: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_cmd |=> (flag_to && !flag_pl));

  a_r9_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |-> !flag_to);
endmodule

bind shared_prescale_timer tw_checker #(.CNT_W(CNT_W)) u_tw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_we       (cnt_we),
  .cnt_wdata    (cnt_wdata),
  .wdt_clear    (wdt_clear),
  .sleep_cmd    (sleep_cmd),
  .cnt_value    (cnt_value),
  .wdt_reset_req(wdt_reset_req),
  .flag_to      (flag_to),
  .flag_pl      (flag_pl)
);

// File: tb/shared_prescale_timer_bench.sv
`timescale 1ns/1ps
module shared_prescale_timer_bench;
  localparam int WDT_W   = 4;
  localparam int WD_EVTS = 1 << WDT_W;
  localparam int NV      = 5;

  localparam logic [5:0] V_MODE [NV] = '{6'b001000, 6'b000000, 6'b000010, 6'b000111, 6'b001000};
  localparam int         V_WAIT [NV] = '{12, 12, 30, 600, 300};
  localparam logic [7:0] V_EXP  [NV] = '{8'd10, 8'd5, 8'd3, 8'd2, 8'd42};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, wdt_tick = 1'b0, mode_we = 1'b0, cnt_we = 1'b0;
  logic       wdt_clear = 1'b0, sleep_cmd = 1'b0;
  logic [5:0] mode_wdata = '0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_value;
  logic       wdt_reset_req, flag_to, flag_pl;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shared_prescale_timer #(.WDT_W(WDT_W)) u_shared_prescale_timer (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .wdt_tick(wdt_tick),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .wdt_clear(wdt_clear), .sleep_cmd(sleep_cmd),
    .cnt_value(cnt_value), .wdt_reset_req(wdt_reset_req),
    .flag_to(flag_to), .flag_pl(flag_pl)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mode_write(input logic [5:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(posedge clk); @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic cnt_load(input logic [7:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(posedge clk); @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk); wdt_tick = 1'b1;
    @(posedge clk); @(negedge clk); wdt_tick = 1'b0;
  endtask

  task automatic ticks_no_req(input int k, input string tag);
    int seen = 0;
    for (int i = 0; i < k; i++) begin
      tick_once();
      if (wdt_reset_req) seen++;
    end
    check(tag, seen, 0);
  endtask

  task automatic pulse_cmd(input logic clr, input logic slp);
    @(negedge clk); wdt_clear = clr; sleep_cmd = slp;
    @(posedge clk); @(negedge clk); wdt_clear = 1'b0; sleep_cmd = 1'b0;
  endtask

  task automatic pin_pulse();
    @(negedge clk); ext_pin = 1'b1;
    repeat (3) @(negedge clk);
    ext_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges(10);
    // R1 reset state; pin idle so a pin-sourced counter stays put
    check("R1 cnt", cnt_value, 0);
    check("R1 flag_to", flag_to, 1);
    check("R1 flag_pl", flag_pl, 1);
    check("R1 req", wdt_reset_req, 0);

    // Vector table: internal source, bypass (R2) and counter ratios (R3)
    for (int i = 0; i < NV; i++) begin
      mode_write(V_MODE[i]);
      cnt_load(8'h00);
      edges(V_WAIT[i]);
      check((V_MODE[i][3]) ? "R2 bypass count" : "R3 ratio count", cnt_value, V_EXP[i]);
    end

    // R5 load, two-cycle hold, wrap
    mode_write(6'b001000);
    cnt_load(8'hFE);
    check("R5 load", cnt_value, 8'hFE);
    edges(1); check("R5 hold1", cnt_value, 8'hFE);
    edges(1); check("R5 hold2", cnt_value, 8'hFE);
    edges(1); check("R5 first inc", cnt_value, 8'hFF);
    edges(1); check("R5 wrap", cnt_value, 8'h00);

    // R5 load clears counter-side prescaler
    mode_write(6'b000000);
    cnt_load(8'h00);
    edges(4);
    check("R5 pre setup", cnt_value, 1);
    cnt_load(8'h00);
    edges(2);
    check("R5 pre cleared", cnt_value, 0);

    // R4 rising edges on pin
    mode_write(6'b101000);
    cnt_load(8'h00);
    edges(4);
    for (int i = 0; i < 3; i++) pin_pulse();
    edges(4);
    check("R4 rising", cnt_value, 3);

    // R4 falling edges; a rise alone is ignored
    mode_write(6'b111000);
    cnt_load(8'h00);
    edges(4);
    @(negedge clk); ext_pin = 1'b1;
    edges(5);
    check("R4 rise ignored", cnt_value, 0);
    ext_pin = 1'b0;
    edges(5);
    check("R4 falling", cnt_value, 1);
    for (int i = 0; i < 2; i++) pin_pulse();
    edges(4);
    check("R4 falling total", cnt_value, 3);

    // R6 direct watchdog, R9 awake timeout
    mode_write(6'b000000);
    pulse_cmd(1'b1, 1'b0);
    check("R7 flag_to", flag_to, 1);
    check("R7 flag_pl", flag_pl, 1);
    ticks_no_req(WD_EVTS - 1, "R6 early req");
    tick_once();
    check("R6 req", wdt_reset_req, 1);
    check("R9 awake flag_to", flag_to, 0);
    check("R9 awake flag_pl", flag_pl, 1);
    @(negedge clk);
    check("R6 req one cycle", wdt_reset_req, 0);

    // R7 clear restarts count
    ticks_no_req(10, "R7 pre-clear");
    pulse_cmd(1'b1, 1'b0);
    ticks_no_req(WD_EVTS - 1, "R7 after clear");
    tick_once();
    check("R7 timeout after clear", wdt_reset_req, 1);

    // R8 sleep, R9 asleep timeout
    pulse_cmd(1'b0, 1'b1);
    check("R8 flag_to", flag_to, 1);
    check("R8 flag_pl", flag_pl, 0);
    ticks_no_req(WD_EVTS - 1, "R8 sleep early");
    tick_once();
    check("R9 sleep req", wdt_reset_req, 1);
    check("R9 sleep flag_to", flag_to, 0);
    check("R9 sleep flag_pl", flag_pl, 0);
    ticks_no_req(WD_EVTS - 1, "R9 rerun");
    tick_once();
    check("R9 woke flag_pl", flag_pl, 1);

    // R8 sleep wins over simultaneous clear
    pulse_cmd(1'b1, 1'b1);
    check("R8 both flag_to", flag_to, 1);
    check("R8 both flag_pl", flag_pl, 0);

    // R6 watchdog prescale 1:2, and R7 clear resets that prescaler
    mode_write(6'b001001);
    pulse_cmd(1'b1, 1'b0);
    tick_once();
    pulse_cmd(1'b1, 1'b0);
    ticks_no_req(2 * WD_EVTS - 1, "R7 pre clear wdt side");
    tick_once();
    check("R6 ratio2 req", wdt_reset_req, 1);

    // R6 watchdog prescale code 0 is 1:1
    mode_write(6'b001000);
    pulse_cmd(1'b1, 1'b0);
    ticks_no_req(WD_EVTS - 1, "R6 ratio1 early");
    tick_once();
    check("R6 ratio1 req", wdt_reset_req, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule